// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Charge-Pump Control

This block sits between the divided reference and divided feedback counters of a frequency synthesizer and the analog charge pump. It takes one single-cycle strobe per divided period from each counter, works out which stream leads, and drives two registered enables, one for current sourcing and one for current sinking. A polarity input picks which enable a leading reference turns on, to suit loop filters and oscillators of either slope.

The same block handles the pump's idle states. A forced high-impedance input parks the pump off whatever the detector sees. A power-down request is taken in two steps: the pump goes high-impedance first, and the block reports itself disabled one cycle later. A lock monitor counts compare periods in which no pump pulse is wider than a small window. A registered high-current flag combines a software bit with an optional external switch input.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `src_en`, `snk_en`, `pump_hiz`, `pwr_dn`, `hi_current` and `locked` are all 0.
- R2: With `pol_normal` = 1, a `ref_pulse` followed `g` cycles later by a `fb_pulse` makes `snk_en` high for exactly `g` cycles, starting two clock edges after the reference strobe; `src_en` stays 0. A feedback strobe that leads does the reverse: `src_en` high for `g` cycles.
- R3: With `pol_normal` = 0, the roles swap: a leading reference drives `src_en` for `g` cycles and a leading feedback drives `snk_en`.
- R4: Reference and feedback strobes in the same cycle produce no pump activity.
- R5: `src_en` and `snk_en` are never high in the same cycle.
- R6: While `force_hiz` = 1, `pump_hiz` is 1 and both enables are 0, whatever the strobes do.
- R7: When `pd_req` rises, `pump_hiz` goes to 1 and the enables to 0 after the next clock edge while `pwr_dn` stays 0; `pwr_dn` goes to 1 one edge later.
- R8: When `pd_req` falls while powered down, `pwr_dn` and `pump_hiz` both return to 0 after the next edge (with `force_hiz` = 0).
- R9: `hi_current` (registered, one edge of latency) is 1 exactly when `cur_bit` = 1 and either `cur_sw_en` = 0 or `cur_sw_in` = 1.
- R10: `locked` rises after `lock_target` consecutive reference strobes (a target of 0 counts as 1) during which no detector pulse lasted more than `WIN_CYCLES` cycles.
- R11: A detector pulse longer than `WIN_CYCLES` cycles clears `locked` and restarts the count on the following edge; being powered down (or quiescing) also holds `locked` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | One-cycle strobe at the end of each divided reference period |
| fb_pulse | input | 1 | One-cycle strobe at the end of each divided feedback period |
| pol_normal | input | 1 | 1: leading reference sinks; 0: leading reference sources |
| force_hiz | input | 1 | 1 forces the pump to high impedance |
| pd_req | input | 1 | Power-down request |
| cur_bit | input | 1 | Software high-current select |
| cur_sw_en | input | 1 | 1 lets `cur_sw_in` gate the high-current select |
| cur_sw_in | input | 1 | External current-switch level |
| lock_target | input | CNT_W | Good compare periods required for lock |
| src_en | output | 1 | Pump source enable |
| snk_en | output | 1 | Pump sink enable |
| pump_hiz | output | 1 | Pump output is high impedance |
| pwr_dn | output | 1 | Block is powered down |
| hi_current | output | 1 | High pump current selected |
| locked | output | 1 | Lock status |

## Verification
The assertions assume each strobe is high for a single cycle and that `pd_req`, `force_hiz` and the current controls come from logic clocked by `clk`. They also assume `lock_target` stays constant while a lock count is running. The bench changes every input on the falling edge and raises each strobe for exactly one cycle. It sets `lock_target` before the lock scenario starts and leaves it alone until that scenario ends. Compare periods are spaced so that each detector pulse ends well before the next strobe arrives.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PD_RUN     = 2'd0,
    PD_QUIESCE = 2'd1,
    PD_OFF     = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ref_pulse,
  input  logic fb_pulse,
  output logic ref_lead,
  output logic fb_lead
);
  logic ref_set, fb_set;

  always_comb begin
    ref_set = ref_lead | ref_pulse;
    fb_set  = fb_lead  | fb_pulse;
  end

  always_ff @(posedge clk) begin
    if (rst || clr || (ref_set && fb_set)) begin
      ref_lead <= 1'b0;
      fb_lead  <= 1'b0;
    end else begin
      ref_lead <= ref_set;
      fb_lead  <= fb_set;
    end
  end

  // R5
  core_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ref_lead && fb_lead));
endmodule

// File: rtl/pump_gate.sv
module pump_gate
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_lead,
  input  logic fb_lead,
  input  logic pol_normal,
  input  logic force_hiz,
  input  logic pd_req,
  input  logic cur_bit,
  input  logic cur_sw_en,
  input  logic cur_sw_in,
  output logic running,
  output logic src_en,
  output logic snk_en,
  output logic pump_hiz,
  output logic pwr_dn,
  output logic hi_current
);
  pd_state_e state, nxt;
  logic drive;

  always_comb begin
    nxt = state;
    unique case (state)
      PD_RUN:     if (pd_req) nxt = PD_QUIESCE;
      PD_QUIESCE: nxt = pd_req ? PD_OFF : PD_RUN;
      PD_OFF:     if (!pd_req) nxt = PD_RUN;
      default:    nxt = PD_RUN;
    endcase
    drive   = (nxt == PD_RUN) && !force_hiz;
    running = (state == PD_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PD_RUN;
      src_en     <= 1'b0;
      snk_en     <= 1'b0;
      pump_hiz   <= 1'b0;
      pwr_dn     <= 1'b0;
      hi_current <= 1'b0;
    end else begin
      state      <= nxt;
      src_en     <= drive && (pol_normal ? fb_lead : ref_lead);
      snk_en     <= drive && (pol_normal ? ref_lead : fb_lead);
      pump_hiz   <= (nxt != PD_RUN) || force_hiz;
      pwr_dn     <= (nxt == PD_OFF);
      hi_current <= cur_bit && (!cur_sw_en || cur_sw_in);
    end
  end

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(src_en && snk_en));
  // R6
  hiz_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pump_hiz |-> (!src_en && !snk_en));
  // R7
  pd_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_dn) |-> $past(pump_hiz));
  // R7
  pd_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |-> pump_hiz);
endmodule

// File: rtl/lock_detect.sv
module lock_detect #(
  parameter int WIN_CYCLES = 2,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             running,
  input  logic             ref_pulse,
  input  logic             ref_lead,
  input  logic             fb_lead,
  input  logic [CNT_W-1:0] lock_target,
  output logic             locked
);
  localparam int WMAX = WIN_CYCLES + 1;
  localparam int WW   = $clog2(WIN_CYCLES + 2);

  logic [WW-1:0]    width_cnt;
  logic [CNT_W-1:0] good_cnt;
  logic [CNT_W:0]   good_next;
  logic [CNT_W-1:0] tgt_eff;
  logic             active, viol;

  always_comb begin
    active    = ref_lead | fb_lead;
    viol      = active && (width_cnt >= WW'(WIN_CYCLES));
    tgt_eff   = (lock_target == '0) ? CNT_W'(1) : lock_target;
    good_next = {1'b0, good_cnt} + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !running) begin
      width_cnt <= '0;
    end else if (active) begin
      if (width_cnt != WW'(WMAX)) width_cnt <= width_cnt + 1'b1;
    end else begin
      width_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !running || viol) begin
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (ref_pulse && !locked) begin
      if (good_next >= {1'b0, tgt_eff}) locked <= 1'b1;
      else                               good_cnt <= good_next[CNT_W-1:0];
    end
  end

  // R11
  viol_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    viol |=> !locked);
  // R10
  lock_on_ref_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(ref_pulse));
  // R11
  pd_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> !locked);
endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl #(
  parameter int WIN_CYCLES = 2,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  input  logic             pol_normal,
  input  logic             force_hiz,
  input  logic             pd_req,
  input  logic             cur_bit,
  input  logic             cur_sw_en,
  input  logic             cur_sw_in,
  input  logic [CNT_W-1:0] lock_target,
  output logic             src_en,
  output logic             snk_en,
  output logic             pump_hiz,
  output logic             pwr_dn,
  output logic             hi_current,
  output logic             locked
);
  logic ref_lead, fb_lead, running;

  pfd_core u_core (
    .clk      (clk),
    .rst      (rst),
    .clr      (!running),
    .ref_pulse(ref_pulse),
    .fb_pulse (fb_pulse),
    .ref_lead (ref_lead),
    .fb_lead  (fb_lead)
  );

  pump_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .ref_lead  (ref_lead),
    .fb_lead   (fb_lead),
    .pol_normal(pol_normal),
    .force_hiz (force_hiz),
    .pd_req    (pd_req),
    .cur_bit   (cur_bit),
    .cur_sw_en (cur_sw_en),
    .cur_sw_in (cur_sw_in),
    .running   (running),
    .src_en    (src_en),
    .snk_en    (snk_en),
    .pump_hiz  (pump_hiz),
    .pwr_dn    (pwr_dn),
    .hi_current(hi_current)
  );

  lock_detect #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .running    (running),
    .ref_pulse  (ref_pulse),
    .ref_lead   (ref_lead),
    .fb_lead    (fb_lead),
    .lock_target(lock_target),
    .locked     (locked)
  );
endmodule

// File: tb/test_pfd_pump_ctrl.sv
`timescale 1ns/1ps
module test_pfd_pump_ctrl;
  localparam int CNT_W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_pulse = 0, fb_pulse = 0, pol_normal = 1, force_hiz = 0, pd_req = 0;
  logic cur_bit = 0, cur_sw_en = 0, cur_sw_in = 0;
  logic [CNT_W-1:0] lock_target = 8'd4;
  logic src_en, snk_en, pump_hiz, pwr_dn, hi_current, locked;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pfd_pump_ctrl #(.WIN_CYCLES(2), .CNT_W(CNT_W)) i_pfd_pump_ctrl (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .pol_normal(pol_normal), .force_hiz(force_hiz), .pd_req(pd_req),
    .cur_bit(cur_bit), .cur_sw_en(cur_sw_en), .cur_sw_in(cur_sw_in),
    .lock_target(lock_target), .src_en(src_en), .snk_en(snk_en),
    .pump_hiz(pump_hiz), .pwr_dn(pwr_dn), .hi_current(hi_current),
    .locked(locked));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ref strobe at cycle ra, fb strobe at cycle fa; counts pump cycles
  task automatic pulse_pair(int ra, int fa, output int n_src, output int n_snk,
                            output int n_both);
    n_src = 0; n_snk = 0; n_both = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      n_src  += int'(src_en);
      n_snk  += int'(snk_en);
      n_both += int'(src_en && snk_en);
      ref_pulse = (c == ra);
      fb_pulse  = (c == fa);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 src", src_en, 0); check("R1 snk", snk_en, 0);
    check("R1 hiz", pump_hiz, 0); check("R1 pwr_dn", pwr_dn, 0);
    check("R1 hi_current", hi_current, 0); check("R1 locked", locked, 0);
    rst = 0;
    @(negedge clk);
    check("R1 after release", {src_en, snk_en, pump_hiz, pwr_dn, locked}, 0);
  endtask

  task automatic t_polarity;
    int s, k, b;
    pol_normal = 1;
    pulse_pair(1, 4, s, k, b);
    check("R2 ref lead sink", k, 3); check("R2 ref lead source", s, 0);
    check("R5 overlap", b, 0);
    pulse_pair(2, 1, s, k, b);
    check("R2 fb lead source", s, 1); check("R2 fb lead sink", k, 0);
    pol_normal = 0;
    pulse_pair(1, 6, s, k, b);
    check("R3 ref lead source", s, 5); check("R3 ref lead sink", k, 0);
    pulse_pair(5, 3, s, k, b);
    check("R3 fb lead sink", k, 2); check("R3 fb lead source", s, 0);
    pol_normal = 1;
  endtask

  task automatic t_equal;
    int s, k, b;
    pulse_pair(2, 2, s, k, b);
    check("R4 equal source", s, 0); check("R4 equal sink", k, 0);
  endtask

  task automatic t_force_hiz;
    int s, k, b;
    force_hiz = 1;
    pulse_pair(1, 5, s, k, b);
    check("R6 hiz", pump_hiz, 1);
    check("R6 enables", s + k, 0);
    force_hiz = 0;
    @(negedge clk);
    check("R6 release", pump_hiz, 0);
  endtask

  task automatic t_current;
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {cur_bit, cur_sw_en, cur_sw_in} = 3'(v);
      @(negedge clk);
      check("R9 hi_current", hi_current,
            int'(v[2] && (!v[1] || v[0])));
    end
    {cur_bit, cur_sw_en, cur_sw_in} = 3'b000;
  endtask

  task automatic periods(int n, int lag);
    for (int p = 0; p < n; p++) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        ref_pulse = (c == 0);
        fb_pulse  = (c == lag);
      end
    end
    @(negedge clk); ref_pulse = 0; fb_pulse = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_lock;
    lock_target = 8'd4;
    periods(2, 1);
    check("R10 not yet locked", locked, 0);
    periods(4, 1);
    check("R10 locked", locked, 1);
    periods(1, 5);
    check("R11 wide pulse unlocks", locked, 0);
    periods(5, 2);
    check("R10 relock at window edge", locked, 1);
  endtask

  task automatic t_power_down;
    @(negedge clk); pd_req = 1;
    @(negedge clk);
    check("R7 hiz first", pump_hiz, 1); check("R7 not yet down", pwr_dn, 0);
    check("R7 enables off", src_en + snk_en, 0);
    @(negedge clk);
    check("R7 down", pwr_dn, 1);
    check("R11 lock cleared in power-down", locked, 0);
    repeat (3) @(negedge clk);
    pd_req = 0;
    @(negedge clk);
    check("R8 pwr_dn release", pwr_dn, 0); check("R8 hiz release", pump_hiz, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_polarity();
    t_equal();
    t_force_hiz();
    t_current();
    t_lock();
    t_power_down();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule